// File: doc/BRIEF.md
# Display Window Refresh Sequencer

This block refreshes a rectangular region of a display controller's frame memory. The controller is driven through a byte-wide command/parameter channel that follows the usual DCS command set. A client gives a rectangle as a start corner and an exclusive end corner, then pulses a request. The sequencer programs the column window and then the row window, each with inclusive end coordinates. It then opens a memory write and streams RGB565 pixels from a ready/valid pixel source. Each pixel goes out as two parameter bytes.

A second request, blank, paints the whole panel black. It uses a window that covers every pixel and sends zero data without reading the pixel source. It is meant for the moment the pipeline is switched off on a panel with no backlight control. After reset the block first runs the panel power-up sequence. It holds the panel reset line low, releases it, and waits out the settle time before it accepts any request.

Top module: `dbi_window_seq`

## Requirements
- R1: After `rst`, `panel_rst_n_o` is low for `RST_LOW_CYC` cycles (counting the cycle in which reset is released). It is then high for `RST_WAIT_CYC` cycles before `init_done_o` rises. Requests made before `init_done_o` is high are ignored.
- R2: An accepted update first emits command byte 0x2A (`out_is_cmd_o`=1) and then four parameter bytes (`out_is_cmd_o`=0): x0 high, x0 low, (x1-1) high, (x1-1) low.
- R3: The column command is followed by command byte 0x2B and four parameter bytes in the same layout for y0 and y1-1.
- R4: Command byte 0x2C follows, then exactly 2·(x1-x0)·(y1-y0) parameter bytes. Each pixel word is taken from the source once and sent high byte first, in the order the source supplies the words.
- R5: Both bytes of an end coordinate come from the value minus one. For example, x1=256 gives 0x00, 0xFF.
- R6: An update request is ignored while `enable_i` is low.
- R7: `busy_o` is high from the cycle after an accepted request until the cycle after the last byte is accepted. Requests arriving while busy are ignored. No byte is offered and no pixel is requested while idle.
- R8: A rectangle with x1≤x0 or y1≤y0 sends no byte, never raises `busy_o`, and pulses `done_o` in the cycle after the request.
- R9: A blank request uses the window (0,0)–(PANEL_W-1,PANEL_H-1) and sends only zero pixel bytes. It never raises `pix_ready_o`, it is taken even with `enable_i` low, and it wins over a simultaneous update request.
- R10: While `out_valid_o` is high and `out_ready_i` is low, the offered byte and its command flag hold unchanged into the next cycle.
- R11: `done_o` is a single-cycle pulse in the cycle after the final byte is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable_i | input | 1 | Pipeline enabled; gates update requests |
| upd_req_i | input | 1 | Update request strobe |
| blank_req_i | input | 1 | Blank-panel request strobe |
| x0_i | input | 16 | Start column |
| y0_i | input | 16 | Start row |
| x1_i | input | 16 | Exclusive end column |
| y1_i | input | 16 | Exclusive end row |
| pix_valid_i | input | 1 | Pixel word available |
| pix_data_i | input | 16 | RGB565 pixel word |
| pix_ready_o | output | 1 | Pixel word taken this cycle when valid |
| out_valid_o | output | 1 | Byte offered to the controller |
| out_ready_i | input | 1 | Controller accepts the offered byte |
| out_is_cmd_o | output | 1 | Offered byte is a command (1) or parameter (0) |
| out_byte_o | output | 8 | Offered byte |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| panel_rst_n_o | output | 1 | Active-low panel reset line |
| init_done_o | output | 1 | Power-up sequence complete |

## Verification
The bound checker watches the cycle-level rules on every cycle. These are that the offered byte holds under backpressure, that nothing is offered or requested while idle, that completion is a one-cycle pulse, and that the power-up order keeps requests out. The byte content can only be shown by the bench's scenarios, which compare against a stream rebuilt from the rectangle. That content covers the window values and their inclusive ends across the 256 boundary, the exact pixel count and byte order, the zero data of a blank, and the requests that must be dropped (disabled, busy, zero-area, before power-up).

// File: rtl/dbi_seq_pkg.sv
package dbi_seq_pkg;

    // coordinate width fixed by the 16-bit window parameters of the command set
    localparam int unsigned CW     = 16;
    localparam int unsigned PIX_W  = 16;
    localparam int unsigned AREA_W = 2 * CW;

    localparam logic [7:0] CMD_COL_WIN = 8'h2A;
    localparam logic [7:0] CMD_ROW_WIN = 8'h2B;
    localparam logic [7:0] CMD_MEM_WR  = 8'h2C;

    localparam logic [3:0] HDR_LAST = 4'd10;

    typedef logic [CW-1:0] coord_t;

    typedef struct packed {
        coord_t col_lo;
        coord_t col_hi;
        coord_t row_lo;
        coord_t row_hi;
    } win_t;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_HDR,
        SQ_PIX
    } seq_st_t;

    typedef enum logic [1:0] {
        PX_EMPTY,
        PX_HI,
        PX_LO
    } pix_st_t;

    typedef enum logic [1:0] {
        PW_LOW,
        PW_WAIT,
        PW_READY
    } pwr_st_t;

    // byte of the eleven-entry window header at position idx
    function automatic logic [7:0] hdr_byte(logic [3:0] idx, win_t w);
        logic [7:0] b;
        case (idx)
            4'd0:    b = CMD_COL_WIN;
            4'd1:    b = w.col_lo[15:8];
            4'd2:    b = w.col_lo[7:0];
            4'd3:    b = w.col_hi[15:8];
            4'd4:    b = w.col_hi[7:0];
            4'd5:    b = CMD_ROW_WIN;
            4'd6:    b = w.row_lo[15:8];
            4'd7:    b = w.row_lo[7:0];
            4'd8:    b = w.row_hi[15:8];
            4'd9:    b = w.row_hi[7:0];
            default: b = CMD_MEM_WR;
        endcase
        return b;
    endfunction

    function automatic logic hdr_is_cmd(logic [3:0] idx);
        return (idx == 4'd0) || (idx == 4'd5) || (idx == HDR_LAST);
    endfunction

endpackage

// File: rtl/dbi_power_seq.sv
module dbi_power_seq
    import dbi_seq_pkg::*;
#(
    parameter int unsigned RST_LOW_CYC  = 2_000_000,
    parameter int unsigned RST_WAIT_CYC = 12_000_000
) (
    input  logic clk,
    input  logic rst,
    output logic panel_rst_n,
    output logic ready
);
    localparam int unsigned CNT_MAX = (RST_LOW_CYC > RST_WAIT_CYC) ? RST_LOW_CYC : RST_WAIT_CYC;
    localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] LOW_END  = CNT_W'(RST_LOW_CYC - 1);
    localparam logic [CNT_W-1:0] WAIT_END = CNT_W'(RST_WAIT_CYC - 1);

    pwr_st_t          ph;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph  <= PW_LOW;
            cnt <= '0;
        end else begin
            case (ph)
                PW_LOW: begin
                    if (cnt == LOW_END) begin
                        ph  <= PW_WAIT;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PW_WAIT: begin
                    if (cnt == WAIT_END) begin
                        ph  <= PW_READY;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    ph  <= PW_READY;
                    cnt <= '0;
                end
            endcase
        end
    end

    assign panel_rst_n = (ph != PW_LOW);
    assign ready       = (ph == PW_READY);

endmodule

// File: rtl/dbi_hdr_gen.sv
module dbi_hdr_gen
    import dbi_seq_pkg::*;
(
    input  logic [3:0] idx,
    input  win_t       win,
    output logic [7:0] hbyte,
    output logic       hcmd,
    output logic       hlast
);
    always_comb begin
        hbyte = hdr_byte(idx, win);
        hcmd  = hdr_is_cmd(idx);
        hlast = (idx == HDR_LAST);
    end
endmodule

// File: rtl/dbi_pix_stream.sv
module dbi_pix_stream
    import dbi_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              active,
    input  logic              zero_fill,
    input  logic [AREA_W-1:0] npix,
    input  logic              pix_valid,
    input  logic [PIX_W-1:0]  pix_data,
    output logic              pix_ready,
    output logic              bvalid,
    output logic [7:0]        bdata,
    input  logic              bready,
    output logic              finish
);
    pix_st_t           st;
    logic [PIX_W-1:0]  hold;
    logic [AREA_W-1:0] sent;
    logic              is_last;

    assign is_last = (sent == npix - 1'b1);

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            st   <= PX_EMPTY;
            hold <= '0;
            sent <= '0;
        end else begin
            case (st)
                PX_EMPTY: begin
                    if (zero_fill) begin
                        hold <= '0;
                        st   <= PX_HI;
                    end else if (pix_valid) begin
                        hold <= pix_data;
                        st   <= PX_HI;
                    end
                end
                PX_HI: begin
                    if (bready) st <= PX_LO;
                end
                default: begin
                    if (bready) begin
                        sent <= sent + 1'b1;
                        st   <= PX_EMPTY;
                    end
                end
            endcase
        end
    end

    always_comb begin
        pix_ready = active && !zero_fill && (st == PX_EMPTY);
        bvalid    = active && (st != PX_EMPTY);
        bdata     = (st == PX_HI) ? hold[15:8] : hold[7:0];
        finish    = active && (st == PX_LO) && bready && is_last;
    end

endmodule

// File: rtl/dbi_window_seq.sv
module dbi_window_seq
    import dbi_seq_pkg::*;
#(
    parameter int unsigned PANEL_W      = 320,
    parameter int unsigned PANEL_H      = 240,
    parameter int unsigned RST_LOW_CYC  = 2_000_000,
    parameter int unsigned RST_WAIT_CYC = 12_000_000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        enable_i,
    input  logic        upd_req_i,
    input  logic        blank_req_i,
    input  logic [15:0] x0_i,
    input  logic [15:0] y0_i,
    input  logic [15:0] x1_i,
    input  logic [15:0] y1_i,
    input  logic        pix_valid_i,
    input  logic [15:0] pix_data_i,
    output logic        pix_ready_o,
    output logic        out_valid_o,
    input  logic        out_ready_i,
    output logic        out_is_cmd_o,
    output logic [7:0]  out_byte_o,
    output logic        busy_o,
    output logic        done_o,
    output logic        panel_rst_n_o,
    output logic        init_done_o
);
    localparam coord_t PW_C = CW'(PANEL_W);
    localparam coord_t PH_C = CW'(PANEL_H);

    seq_st_t           st;
    win_t              win;
    logic [AREA_W-1:0] npix;
    logic              zero_mode;
    logic [3:0]        hidx;
    logic              done_q;
    logic              ready_pwr;

    // request selection and window arithmetic
    logic              take_blank, take_upd, take_any;
    coord_t            ax0, ay0, ax1, ay1, wid, hgt;
    logic [AREA_W-1:0] area;

    always_comb begin
        take_blank = ready_pwr && (st == SQ_IDLE) && blank_req_i;
        take_upd   = ready_pwr && (st == SQ_IDLE) && upd_req_i && enable_i && !blank_req_i;
        take_any   = take_blank || take_upd;
        ax0 = blank_req_i ? '0   : x0_i;
        ay0 = blank_req_i ? '0   : y0_i;
        ax1 = blank_req_i ? PW_C : x1_i;
        ay1 = blank_req_i ? PH_C : y1_i;
        wid  = (ax1 > ax0) ? (ax1 - ax0) : '0;
        hgt  = (ay1 > ay0) ? (ay1 - ay0) : '0;
        area = AREA_W'(wid) * AREA_W'(hgt);
    end

    // header generator
    logic [7:0] h_byte;
    logic       h_cmd, h_last;

    dbi_hdr_gen u_hdr (
        .idx   (hidx),
        .win   (win),
        .hbyte (h_byte),
        .hcmd  (h_cmd),
        .hlast (h_last)
    );

    // pixel serializer
    logic       p_valid, p_finish;
    logic [7:0] p_byte;

    dbi_pix_stream u_pix (
        .clk       (clk),
        .rst       (rst),
        .active    (st == SQ_PIX),
        .zero_fill (zero_mode),
        .npix      (npix),
        .pix_valid (pix_valid_i),
        .pix_data  (pix_data_i),
        .pix_ready (pix_ready_o),
        .bvalid    (p_valid),
        .bdata     (p_byte),
        .bready    (out_ready_i),
        .finish    (p_finish)
    );

    // power-up sequencing
    dbi_power_seq #(
        .RST_LOW_CYC  (RST_LOW_CYC),
        .RST_WAIT_CYC (RST_WAIT_CYC)
    ) u_pwr (
        .clk         (clk),
        .rst         (rst),
        .panel_rst_n (panel_rst_n_o),
        .ready       (ready_pwr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= SQ_IDLE;
            win       <= '0;
            npix      <= '0;
            zero_mode <= 1'b0;
            hidx      <= '0;
            done_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (st)
                SQ_IDLE: begin
                    if (take_any) begin
                        if (area == '0) begin
                            done_q <= 1'b1;
                        end else begin
                            win.col_lo <= ax0;
                            win.col_hi <= ax1 - 1'b1;
                            win.row_lo <= ay0;
                            win.row_hi <= ay1 - 1'b1;
                            npix       <= area;
                            zero_mode  <= take_blank;
                            hidx       <= '0;
                            st         <= SQ_HDR;
                        end
                    end
                end
                SQ_HDR: begin
                    if (out_ready_i) begin
                        if (h_last) st <= SQ_PIX;
                        else        hidx <= hidx + 1'b1;
                    end
                end
                default: begin
                    if (p_finish) begin
                        st     <= SQ_IDLE;
                        done_q <= 1'b1;
                    end
                end
            endcase
        end
    end

    always_comb begin
        out_valid_o  = (st == SQ_HDR) || p_valid;
        out_byte_o   = (st == SQ_HDR) ? h_byte : p_byte;
        out_is_cmd_o = (st == SQ_HDR) && h_cmd;
        busy_o       = (st != SQ_IDLE);
        done_o       = done_q;
        init_done_o  = ready_pwr;
    end

endmodule

// File: rtl/dbi_window_seq_chk.sv
module dbi_window_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       busy_o,
    input logic       out_valid_o,
    input logic       out_ready_i,
    input logic [7:0] out_byte_o,
    input logic       out_is_cmd_o,
    input logic       done_o,
    input logic       pix_ready_o,
    input logic       panel_rst_n_o,
    input logic       init_done_o
);
    // R10
    hold_out_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_byte_o) && $stable(out_is_cmd_o));

    // R7
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> !out_valid_o && !pix_ready_o);

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R7
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);

    // R1
    init_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !init_done_o |-> !busy_o && !done_o);

    // R1
    rst_order_chk: assert property (@(posedge clk) disable iff (rst)
        !panel_rst_n_o |-> !init_done_o);
endmodule

bind dbi_window_seq dbi_window_seq_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .busy_o        (busy_o),
    .out_valid_o   (out_valid_o),
    .out_ready_i   (out_ready_i),
    .out_byte_o    (out_byte_o),
    .out_is_cmd_o  (out_is_cmd_o),
    .done_o        (done_o),
    .pix_ready_o   (pix_ready_o),
    .panel_rst_n_o (panel_rst_n_o),
    .init_done_o   (init_done_o)
);

// File: tb/test_dbi_window_seq.sv
module test_dbi_window_seq;
    localparam int PW = 8;
    localparam int PH = 4;
    localparam int T_LOW = 20;
    localparam int T_WAIT = 120;
    localparam int NV = 7;
    // x0, y0, x1, y1, stall
    localparam int TBL [NV][5] = '{
        '{0,   0,   1,   1,   0},
        '{3,   2,   7,   5,   0},
        '{254, 510, 256, 512, 0},
        '{300, 1,   303, 3,   1},
        '{10,  10,  10,  20,  0},
        '{5,   9,   8,   9,   0},
        '{9,   4,   5,   6,   1}
    };

    logic clk = 0;
    logic rst = 1;
    logic enable_i = 0, upd_req_i = 0, blank_req_i = 0;
    logic [15:0] x0_i = 0, y0_i = 0, x1_i = 0, y1_i = 0;
    logic pix_valid_i = 1;
    logic [15:0] pix_data_i = 0;
    logic pix_ready_o, out_valid_o, out_is_cmd_o, busy_o, done_o, panel_rst_n_o, init_done_o;
    logic out_ready_i = 1;
    logic [7:0] out_byte_o;

    always #2 clk = ~clk;

    dbi_window_seq #(.PANEL_W(PW), .PANEL_H(PH), .RST_LOW_CYC(T_LOW), .RST_WAIT_CYC(T_WAIT)) i_dbi_window_seq (
        .clk(clk), .rst(rst), .enable_i(enable_i), .upd_req_i(upd_req_i), .blank_req_i(blank_req_i),
        .x0_i(x0_i), .y0_i(y0_i), .x1_i(x1_i), .y1_i(y1_i),
        .pix_valid_i(pix_valid_i), .pix_data_i(pix_data_i), .pix_ready_o(pix_ready_o),
        .out_valid_o(out_valid_o), .out_ready_i(out_ready_i), .out_is_cmd_o(out_is_cmd_o),
        .out_byte_o(out_byte_o), .busy_o(busy_o), .done_o(done_o),
        .panel_rst_n_o(panel_rst_n_o), .init_done_o(init_done_o)
    );

    int nchk = 0, nfail = 0, cyc = 0, pidx = 0, nb = 0;
    bit rdy = 1, saw_pix, saw_done, saw_busy, saw_any;
    logic [7:0] cb [0:1023];
    bit cc [0:1023];

    always @(posedge clk) cyc <= cyc + 1;

    initial begin
        wait (cyc >= 150000);
        nfail++; nchk++;
        $display("FAIL watchdog: got=%0d cycles exp=<150000", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    task automatic chk(input bit ok, input string tag, input int got, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: got=%0d exp=%0d", tag, got, exp);
        end
    endtask

    function automatic logic [15:0] pat(input int k);
        return 16'(32'h3C5A + k * 32'h0123);
    endfunction

    task automatic step(input bit stall);
        @(negedge clk);
        upd_req_i = 0; blank_req_i = 0;
        rdy = stall ? !rdy : 1'b1;
        out_ready_i = rdy;
        pix_data_i = pat(pidx);
        if (pix_ready_o) begin pidx++; saw_pix = 1; end
        if (out_valid_o && rdy) begin
            if (nb < 1024) begin cb[nb] = out_byte_o; cc[nb] = out_is_cmd_o; end
            nb++;
        end
        if (busy_o) saw_busy = 1;
        if (done_o) saw_done = 1;
    endtask

    task automatic check_op(input int x0, input int y0, input int x1, input int y1,
                            input bit blank, input int base, input bit stall);
        int w, h, area, hm, fm, pm;
        int hb [11];
        logic [15:0] px;
        logic [7:0] eb;
        w = (x1 > x0) ? x1 - x0 : 0;
        h = (y1 > y0) ? y1 - y0 : 0;
        area = w * h;
        if (area == 0) begin
            chk(nb == 0, "R8 zero-area bytes", nb, 0);
            chk(saw_done, "R8 zero-area done", saw_done, 1);
            chk(!saw_busy, "R8 zero-area busy", saw_busy, 0);
            return;
        end
        hb = '{8'h2A, (x0 >> 8) & 255, x0 & 255, ((x1-1) >> 8) & 255, (x1-1) & 255,
               8'h2B, (y0 >> 8) & 255, y0 & 255, ((y1-1) >> 8) & 255, (y1-1) & 255, 8'h2C};
        chk(nb == 11 + 2*area, "R4 byte count", nb, 11 + 2*area);
        hm = 0; fm = 0; pm = 0;
        for (int i = 0; i < 11 && i < nb; i++) begin
            if (int'(cb[i]) != hb[i]) hm++;
            if (cc[i] != (i == 0 || i == 5 || i == 10)) fm++;
        end
        chk(hm == 0, "R2 R3 R5 window header mismatches", hm, 0);
        for (int j = 0; j < 2*area && 11 + j < nb && 11 + j < 1024; j++) begin
            px = blank ? 16'h0 : pat(base + j/2);
            eb = (j % 2 == 0) ? px[15:8] : px[7:0];
            if (cb[11+j] != eb) pm++;
            if (cc[11+j]) fm++;
        end
        chk(fm == 0, "R2 command flag mismatches", fm, 0);
        if (blank) chk(pm == 0, "R9 zero pixel mismatches", pm, 0);
        else if (stall) chk(pm == 0, "R4 R10 pixel mismatches under backpressure", pm, 0);
        else chk(pm == 0, "R4 pixel mismatches", pm, 0);
        chk(saw_busy, "R7 busy seen", saw_busy, 1);
    endtask

    task automatic run_op(input int x0, input int y0, input int x1, input int y1,
                          input bit blank, input bit stall, input bit intrude);
        int base;
        @(negedge clk);
        x0_i = 16'(x0); y0_i = 16'(y0); x1_i = 16'(x1); y1_i = 16'(y1);
        if (blank) blank_req_i = 1; else upd_req_i = 1;
        nb = 0; saw_pix = 0; saw_done = 0; saw_busy = 0;
        base = pidx;
        for (int i = 0; i < 3000 && !saw_done; i++) begin
            step(stall);
            if (intrude && i == 4) begin
                upd_req_i = 1; x1_i = 16'(x1 + 5);
            end
        end
        check_op(x0, y0, x1, y1, blank, base, stall);
        step(0);
        chk(!done_o, "R11 done width", done_o, 0);
    endtask

    initial begin
        int lowc, waitc;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(!panel_rst_n_o, "R1 panel reset low in reset", panel_rst_n_o, 0);
        chk(!busy_o && !out_valid_o, "R7 idle in reset", busy_o, 0);
        chk(!init_done_o, "R1 init_done low in reset", init_done_o, 0);
        rst = 0;
        lowc = 0;
        while (!panel_rst_n_o && lowc < 1000) begin lowc++; @(negedge clk); end
        chk(lowc == T_LOW, "R1 reset low cycles", lowc, T_LOW);
        waitc = 0; saw_any = 0; enable_i = 1;
        x0_i = 0; y0_i = 0; x1_i = 4; y1_i = 4;
        while (!init_done_o && waitc < 1000) begin
            upd_req_i = (waitc == 10) || (waitc == T_WAIT - 1);
            waitc++;
            @(negedge clk);
            if (busy_o || out_valid_o || done_o) saw_any = 1;
        end
        upd_req_i = 0;
        chk(waitc == T_WAIT, "R1 settle cycles", waitc, T_WAIT);
        repeat (5) begin @(negedge clk); if (busy_o || out_valid_o || done_o) saw_any = 1; end
        chk(!saw_any, "R1 early request ignored", saw_any, 0);

        // table of rectangles
        for (int k = 0; k < NV; k++)
            run_op(TBL[k][0], TBL[k][1], TBL[k][2], TBL[k][3], 0, TBL[k][4] != 0, 0);

        // R6 disabled update dropped
        enable_i = 0;
        @(negedge clk);
        x0_i = 0; y0_i = 0; x1_i = 2; y1_i = 2; upd_req_i = 1;
        nb = 0; saw_done = 0; saw_busy = 0;
        repeat (40) step(0);
        chk(nb == 0 && !saw_busy && !saw_done, "R6 disabled update ignored", nb + saw_busy + saw_done, 0);

        // R9 blank while disabled, wins over update
        @(negedge clk);
        upd_req_i = 1; blank_req_i = 1; x0_i = 1; y0_i = 1; x1_i = 3; y1_i = 3;
        nb = 0; saw_pix = 0; saw_done = 0; saw_busy = 0;
        for (int i = 0; i < 3000 && !saw_done; i++) step(0);
        check_op(0, 0, PW, PH, 1, 0, 0);
        chk(!saw_pix, "R9 pixel source untouched", saw_pix, 0);
        enable_i = 1;

        // R7 request during busy dropped
        run_op(2, 3, 5, 5, 0, 0, 1);
        nb = 0; saw_done = 0; saw_busy = 0;
        repeat (40) step(0);
        chk(nb == 0 && !saw_done && !saw_busy, "R7 request while busy ignored", nb + saw_done, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule